// File: doc/BRIEF.md
# Bit Scan and Bit Test Unit

This block performs single-register bit manipulation for an integer datapath that runs either 32 bits wide or 16 bits wide. It takes a start strobe, an operation code, a destination operand, a source operand, the current zero flag and the current carry flag. The operations are a scan for the lowest set bit, a scan for the highest set bit, four single-bit test operations and a reversal of byte order.

The unit returns the new destination value, a write-enable for that destination, and new zero and carry flags. The four bit-test forms differ only in what they do to the selected bit: keep it, invert it, clear it or set it. All outputs are captured in one register stage, and a valid strobe marks the cycle in which they are ready.

When no start is given, the outputs keep their last captured values.

Top module: `bit_scan_unit`

## Requirements
- R1: Opcode 0 (lowest-first scan) of a nonzero operand gives as result the index of the lowest set bit, zero-extended, with we_o=1 and zf_o=0.
- R2: Opcode 1 (highest-first scan) of a nonzero operand gives as result the index of the highest set bit, zero-extended, with we_o=1 and zf_o=0.
- R3: A scan (opcode 0 or 1) of an all-zero operand gives zf_o=1 and we_o=0, and returns the destination unchanged. Both scans pass cf_i through to cf_o.
- R4: Opcode 2 (test) copies bit n of the destination into cf_o, returns the destination unchanged with we_o=0, and passes zf_i through.
- R5: Opcodes 3, 4 and 5 copy the old bit n into cf_o and write the destination with we_o=1. Opcode 3 inverts bit n, opcode 4 clears it and opcode 5 sets it. All other bits are unchanged and zf_i is passed through.
- R6: Opcode 6 reverses the byte order of the full 32-bit destination: byte 0 goes to byte 3, byte 1 to byte 2, and so on. It sets we_o=1, and both flags pass through.
- R7: The bit index n is src_i[4:0] when wide_i=1 and src_i[3:0] when wide_i=0. Higher source bits are ignored.
- R8: When wide_i=0, scans look only at dst_i[15:0]. For every opcode except 6, result bits [31:16] equal dst_i[31:16].
- R9: After reset all outputs are 0. valid_o is 1 exactly in the cycle after a cycle with start_i=1. When start_i is 0, the outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the operation this cycle |
| op_i | input | 3 | Operation code (0..6) |
| wide_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand; low bits give the bit index |
| zf_i | input | 1 | Incoming zero flag |
| cf_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | New destination value |
| we_o | output | 1 | Destination write-enable |
| zf_o | output | 1 | New zero flag |
| cf_o | output | 1 | New carry flag |
| valid_o | output | 1 | Result ready strobe |

## Verification
The design has one register stage, so a wrong index from a scanner appears on res_o in the cycle right after the start strobe. A wrong bit mask appears on res_o or cf_o in that same cycle. The bench compares every output field against a behavioural model after each operation and checks that the outputs stay frozen during idle cycles. A mis-decoded width shows as a changed upper half or an index above 15, and the narrow-mode patterns are chosen to expose exactly that.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [2:0] {
    OP_SCAN_LO = 3'd0,
    OP_SCAN_HI = 3'd1,
    OP_TEST    = 3'd2,
    OP_TFLIP   = 3'd3,
    OP_TCLR    = 3'd4,
    OP_TSET    = 3'd5,
    OP_BSWAP   = 3'd6
  } bsu_op_e;
endpackage

// File: rtl/bsu_scan.sv
module bsu_scan #(
  parameter int W       = 32,
  parameter int IDX_W   = $clog2(W),
  parameter bit REVERSE = 1'b0
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  assign found_o = |vec_i;

  generate
    if (REVERSE) begin : g_hi
      // last hit wins: highest set bit
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++)
          if (vec_i[i]) idx_o = IDX_W'(i);
      end
    end else begin : g_lo
      always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--)
          if (vec_i[i]) idx_o = IDX_W'(i);
      end
    end
  endgenerate

  // R1/R2: the reported index points at a set bit
  always_comb begin
    if (found_o === 1'b1)
      p_idx_is_set_r1: assert (vec_i[idx_o]);
  end
endmodule

// File: rtl/bsu_bitop.sv
module bsu_bitop
  import bsu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     dst_i,
  input  logic [IDX_W-1:0] idx_i,
  input  bsu_op_e          op_i,
  output logic             bit_o,
  output logic [W-1:0]     res_o
);
  logic [W-1:0] mask;

  assign mask  = W'(1) << idx_i;
  assign bit_o = dst_i[idx_i];

  always_comb begin
    unique case (op_i)
      OP_TFLIP: res_o = dst_i ^ mask;
      OP_TCLR:  res_o = dst_i & ~mask;
      OP_TSET:  res_o = dst_i | mask;
      default:  res_o = dst_i;
    endcase
  end

  // R5: at most one bit of the destination changes
  always_comb begin
    if (!$isunknown({dst_i, idx_i, op_i}))
      p_single_bit_r5: assert ($countones(res_o ^ dst_i) <= 1);
  end
endmodule

// File: rtl/bsu_bswap.sv
module bsu_bswap #(
  parameter int W     = 32,
  parameter int BYTES = W / 8
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign val_o[8*b +: 8] = val_i[8*(BYTES-1-b) +: 8];
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              zf_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic              valid_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;

  bsu_op_e           op;
  logic [DATA_W-1:0] scan_vec;
  logic [IDX_W-1:0]  bit_idx;
  logic              lo_found, hi_found, test_bit;
  logic [IDX_W-1:0]  lo_idx, hi_idx;
  logic [DATA_W-1:0] bitop_res, swap_res;
  logic [DATA_W-1:0] res_d;
  logic              we_d, zf_d, cf_d;
  bsu_op_e           op_q;

  assign op       = bsu_op_e'(op_i);
  assign scan_vec = wide_i ? dst_i : {{HALF{1'b0}}, dst_i[HALF-1:0]};
  assign bit_idx  = wide_i ? src_i[IDX_W-1:0] : {1'b0, src_i[IDX_W-2:0]};

  bsu_scan #(.W(DATA_W), .REVERSE(1'b0)) u_scan_lo (
    .vec_i(scan_vec), .found_o(lo_found), .idx_o(lo_idx)
  );
  bsu_scan #(.W(DATA_W), .REVERSE(1'b1)) u_scan_hi (
    .vec_i(scan_vec), .found_o(hi_found), .idx_o(hi_idx)
  );
  bsu_bitop #(.W(DATA_W)) u_bitop (
    .dst_i(dst_i), .idx_i(bit_idx), .op_i(op), .bit_o(test_bit), .res_o(bitop_res)
  );
  bsu_bswap #(.W(DATA_W)) u_bswap (
    .val_i(dst_i), .val_o(swap_res)
  );

  always_comb begin
    res_d = dst_i;
    we_d  = 1'b0;
    zf_d  = zf_i;
    cf_d  = cf_i;
    unique case (op)
      OP_SCAN_LO: begin
        zf_d = !lo_found;
        we_d = lo_found;
        if (lo_found) res_d = DATA_W'(lo_idx);
      end
      OP_SCAN_HI: begin
        zf_d = !hi_found;
        we_d = hi_found;
        if (hi_found) res_d = DATA_W'(hi_idx);
      end
      OP_TEST: cf_d = test_bit;
      OP_TFLIP, OP_TCLR, OP_TSET: begin
        cf_d  = test_bit;
        we_d  = 1'b1;
        res_d = bitop_res;
      end
      OP_BSWAP: begin
        we_d  = 1'b1;
        res_d = swap_res;
      end
      default: ;
    endcase
    // narrow mode keeps the upper half
    if (!wide_i && op != OP_BSWAP) res_d[DATA_W-1:HALF] = dst_i[DATA_W-1:HALF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      we_o    <= 1'b0;
      zf_o    <= 1'b0;
      cf_o    <= 1'b0;
      valid_o <= 1'b0;
      op_q    <= OP_SCAN_LO;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        res_o <= res_d;
        we_o  <= we_d;
        zf_o  <= zf_d;
        cf_o  <= cf_d;
        op_q  <= op;
      end
    end
  end

  p_valid_after_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  p_hold_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(res_o) && $stable(we_o) && $stable(zf_o) && $stable(cf_o));
  p_empty_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (op_q == OP_SCAN_LO || op_q == OP_SCAN_HI) && zf_o |-> !we_o);
  p_test_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && op_q == OP_TEST |-> !we_o);
endmodule

// File: tb/bit_scan_unit_tb_top.sv
module bit_scan_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b1;
  logic [31:0] dst = '0, src = '0;
  logic        zf = 1'b0, cf = 1'b0;
  logic [31:0] res;
  logic        we, zfo, cfo, valid;
  int total = 0;
  int bad = 0;

  always #10ns clk = ~clk;

  bit_scan_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .dst_i(dst), .src_i(src), .zf_i(zf), .cf_i(cf),
    .res_o(res), .we_o(we), .zf_o(zfo), .cf_o(cfo), .valid_o(valid)
  );

  task automatic model(input int mop, input bit mw, input logic [31:0] d, input logic [31:0] s,
                       input bit z, input bit c, output logic [31:0] er, output bit ewe,
                       output bit ez, output bit ec);
    int w, n, hit;
    w = mw ? 32 : 16;
    n = mw ? int'(s[4:0]) : int'(s[3:0]);
    er = d; ewe = 0; ez = z; ec = c; hit = -1;
    case (mop)
      0, 1: begin
        for (int i = 0; i < w; i++)
          if (d[i] && (mop == 1 || hit < 0)) hit = i;
        ez = (hit < 0);
        if (hit >= 0) begin
          ewe = 1;
          er = (mw ? 32'd0 : {d[31:16], 16'd0}) | 32'(hit);
        end
      end
      2: ec = d[n];
      3, 4, 5: begin
        ec = d[n]; ewe = 1;
        er[n] = (mop == 3) ? ~d[n] : (mop == 5);
      end
      6: begin
        ewe = 1;
        er = {d[7:0], d[15:8], d[23:16], d[31:24]};
      end
      default: ;
    endcase
  endtask

  task automatic run(input string req, input int mop, input bit mw, input logic [31:0] d,
                     input logic [31:0] s, input bit z, input bit c);
    logic [31:0] er; bit ewe, ez, ec;
    model(mop, mw, d, s, z, c, er, ewe, ez, ec);
    @(negedge clk);
    start = 1; op = 3'(mop); wide = mw; dst = d; src = s; zf = z; cf = c;
    @(negedge clk);
    start = 0; dst = ~d; src = ~s; zf = ~z; cf = ~c;
    total++;
    if (res !== er || we !== ewe || zfo !== ez || cfo !== ec || valid !== 1'b1) begin
      bad++;
      $display("FAIL %s op=%0d w=%0d d=%h s=%h: got res=%h we=%b zf=%b cf=%b v=%b exp res=%h we=%b zf=%b cf=%b v=1",
               req, mop, mw, d, s, res, we, zfo, cfo, valid, er, ewe, ez, ec);
    end
  endtask

  task automatic check_idle(input string req);
    logic [31:0] r0; bit w0, z0, c0;
    r0 = res; w0 = we; z0 = zfo; c0 = cfo;
    @(negedge clk);
    total++;
    if (valid !== 1'b0 || res !== r0 || we !== w0 || zfo !== z0 || cfo !== c0) begin
      bad++;
      $display("FAIL %s idle: got res=%h v=%b exp res=%h v=0", req, res, valid, r0);
    end
  endtask

  initial begin
    #4ms;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (res !== 0 || we !== 0 || zfo !== 0 || cfo !== 0 || valid !== 0) begin
      bad++;
      $display("FAIL R9 reset: got res=%h v=%b exp 0", res, valid);
    end
    rst_n = 1;

    // R3: all-zero operand, both directions and widths
    for (int m = 0; m < 2; m++) begin
      run("R3", m, 1, 32'h0, 0, 0, 1);
      run("R3", m, 0, 32'hABCD_0000, 0, 0, 0);
    end
    // R1 R2: single bit at every position
    for (int i = 0; i < 32; i++) begin
      run("R1", 0, 1, 32'h1 << i, 0, 1, 0);
      run("R2", 1, 1, 32'h1 << i, 0, 1, 1);
    end
    // R1 R2: all ones, mixed patterns
    run("R1", 0, 1, 32'hFFFF_FFFF, 0, 1, 0);
    run("R2", 1, 1, 32'hFFFF_FFFF, 0, 1, 0);
    run("R1", 0, 1, 32'h8000_1000, 0, 0, 0);
    run("R2", 1, 1, 32'h0010_0001, 0, 0, 0);
    // R8: narrow scans ignore upper half, keep it in result
    for (int i = 0; i < 16; i++) begin
      run("R8", 0, 0, 32'hF00F_0000 | (32'h1 << i), 0, 1, 0);
      run("R8", 1, 0, 32'hFFFF_0000 | (32'h1 << i), 0, 1, 1);
    end
    run("R8", 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
    run("R8", 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    // R4 R5 R7: every index, every test form, both widths
    for (int m = 2; m < 6; m++) begin
      for (int i = 0; i < 32; i++) begin
        run(m == 2 ? "R4" : "R5", m, 1, 32'hA5C3_3C5A, 32'(i), i[0], i[1]);
        run(m == 2 ? "R4" : "R5", m, 1, 32'h5A3C_C3A5, 32'hFFFF_FFE0 | 32'(i), 0, 0);
        run("R7", m, 0, 32'h1234_A5C3, 32'(i), 1, i[0]);
        run("R8", m, 0, 32'hFFFF_5A3C, 32'hFFFF_FFF0 | 32'(i), 0, 1);
      end
    end
    // R6: byte reversal in both widths
    run("R6", 6, 1, 32'h1122_3344, 0, 1, 0);
    run("R6", 6, 0, 32'hDEAD_BEEF, 0, 0, 1);
    // mixed random stream
    for (int k = 0; k < 200; k++) begin
      logic [31:0] d, s;
      int m;
      d = $urandom; s = $urandom; m = int'($urandom % 7);
      if (k % 5 == 0) d = d & (32'h1 << (k % 32));
      run("R7", m, k[0], d, s, k[1], k[2]);
    end
    // R9: outputs held with start low
    check_idle("R9");
    check_idle("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule